// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is a single programmable logic cell. It pairs a small truth-table memory, one bit wide and addressed by the cell's data inputs, with one flip-flop. The table is filled through a serial configuration port before the cell is used. After that, two static control bits and one static output select fix how the cell behaves.

In general-logic mode the cell gives any function of its four data inputs. In arithmetic mode the table is split into two halves. One half gives a sum bit and the other gives a carry-out. Both halves are indexed by the two low data inputs and the incoming carry, so cells can be chained into adders, counters and comparators.

The cell output can be taken straight from the table or from the flip-flop. The flip-flop has clock enable, an asynchronous clear, a synchronous clear and a synchronous load. A chain input can feed the flip-flop directly, which lets cells form shift structures. A synchronous reset empties the table and clears the flip-flop.

Top module: `logic_cell`

## Requirements
- R1: While `rst` is high at a clock edge, the table is cleared to all zeros and the register to 0. After reset, `reg_out`, `cell_out` and `carry_out` are all 0.
- R2: Each clock edge with `cfg_en` high shifts `cfg_bit` into table entry 0 and moves every entry up by one. After 16 such edges, the first bit sent sits in entry 15 (MSB first).
- R3: In general-logic mode (`arith_mode`=0) with `out_sel_reg`=0 and `cfg_en`=0, `cell_out` equals table entry `din` combinationally, with `din[0]` as the least significant address bit.
- R4: When loaded with a three-input pattern (the same byte in both halves), the cell reproduces the truth table 1,0,1,1,1,0,1,1 for codes 0 through 7 of `din[2:0]`.
- R5: In arithmetic mode, with index i = {`carry_in`,`din[1]`,`din[0]`}, the sum is entry i and `carry_out` is entry 8+i, and `din[3:2]` has no effect. In general-logic mode `carry_out` is 0.
- R6: With `out_sel_reg`=1, `cell_out` equals `reg_out`.
- R7: On an edge with `ce`=1 and no clear or load, the register takes the table result: the function in general-logic mode, the sum in arithmetic mode. With `ce`=0 the register holds.
- R8: With `chain_mode`=1, captured data comes from `chain_in` in place of the table result.
- R9: `aclr` clears the register at once, without waiting for a clock edge, and overrides every other control.
- R10: `sclr` takes priority over `sload`, and `sload` takes priority over `ce` capture.
- R11: A `sload` edge loads `sload_val` into the register, whether `ce` is high or low.
- R12: While `cfg_en` is high, the table-driven outputs (`cell_out` when `out_sel_reg`=0, and `carry_out`) are 0. The register also ignores `sclr`, `sload` and `ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial table data, MSB first |
| arith_mode | input | 1 | 0 general logic, 1 arithmetic |
| out_sel_reg | input | 1 | 1 selects the register for `cell_out` |
| chain_mode | input | 1 | 1 makes `chain_in` the register data |
| din | input | K | Table address / data inputs |
| carry_in | input | 1 | Carry from the previous cell |
| chain_in | input | 1 | Register-chain input |
| ce | input | 1 | Clock enable |
| aclr | input | 1 | Asynchronous clear |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load |
| sload_val | input | 1 | Value for synchronous load |
| cell_out | output | 1 | Cell output |
| reg_out | output | 1 | Register output, for chaining |
| carry_out | output | 1 | Carry to the next cell |

## Verification
The assertions check on every cycle:
- the register control priorities (asynchronous clear, synchronous clear, load, hold when disabled);
- the freeze and quieting of outputs during configuration;
- the zero carry in general-logic mode;
- the tracking of the register by the output when it is selected.

The scenarios must show the things a cycle-local property cannot see:
- that serial loading lands bits in the right entries;
- that arbitrary truth tables and the full-adder split read back correctly for every input code;
- that the chain input shifts a pattern through.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  typedef enum logic {
    MODE_LOGIC = 1'b0,
    MODE_ARITH = 1'b1
  } cell_mode_e;

  localparam int ARITH_IDX_W = 3;
endpackage

// File: rtl/lcell_table.sv
module lcell_table #(
  parameter int K = 4,
  localparam int DEPTH = 1 << K
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  output logic [DEPTH-1:0] tbl
);
  // Serial fill: new bit enters entry 0, older bits move toward the top.
  always_ff @(posedge clk) begin
    if (rst) begin
      tbl <= '0;
    end else if (cfg_en) begin
      tbl <= {tbl[DEPTH-2:0], cfg_bit};
    end
  end
endmodule

// File: rtl/lcell_eval.sv
module lcell_eval
  import lcell_pkg::*;
#(
  parameter int K = 4,
  localparam int DEPTH = 1 << K
) (
  input  logic [DEPTH-1:0] tbl,
  input  cell_mode_e       mode,
  input  logic             quiet,
  input  logic [K-1:0]     din,
  input  logic             carry_in,
  output logic             lut_o,
  output logic             carry_o
);
  logic [K-1:0] sum_idx;
  logic [K-1:0] cy_idx;
  logic         logic_bit;
  logic         sum_bit;
  logic         cy_bit;

  always_comb begin
    sum_idx = '0;
    sum_idx[ARITH_IDX_W-1:0] = {carry_in, din[1], din[0]};
    cy_idx = sum_idx;
    cy_idx[K-1] = 1'b1;
  end

  assign logic_bit = tbl[din];
  assign sum_bit   = tbl[sum_idx];
  assign cy_bit    = tbl[cy_idx];

  always_comb begin
    lut_o   = 1'b0;
    carry_o = 1'b0;
    if (!quiet) begin
      if (mode == MODE_ARITH) begin
        lut_o   = sum_bit;
        carry_o = cy_bit;
      end else begin
        lut_o   = logic_bit;
      end
    end
  end
endmodule

// File: rtl/lcell_ff.sv
module lcell_ff (
  input  logic clk,
  input  logic rst,
  input  logic aclr,
  input  logic freeze,
  input  logic sclr,
  input  logic sload,
  input  logic sload_val,
  input  logic ce,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      q <= 1'b0;
    end else if (rst) begin
      q <= 1'b0;
    end else if (!freeze) begin
      if (sclr) begin
        q <= 1'b0;
      end else if (sload) begin
        q <= sload_val;
      end else if (ce) begin
        q <= d;
      end
    end
  end
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lcell_pkg::*;
#(
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_bit,
  input  logic         arith_mode,
  input  logic         out_sel_reg,
  input  logic         chain_mode,
  input  logic [K-1:0] din,
  input  logic         carry_in,
  input  logic         chain_in,
  input  logic         ce,
  input  logic         aclr,
  input  logic         sclr,
  input  logic         sload,
  input  logic         sload_val,
  output logic         cell_out,
  output logic         reg_out,
  output logic         carry_out
);
  localparam int DEPTH = 1 << K;

  logic [DEPTH-1:0] tbl;
  logic             lut_o;
  logic             reg_d;
  cell_mode_e       mode;

  assign mode = cell_mode_e'(arith_mode);

  lcell_table #(.K(K)) u_table (
    .clk    (clk),
    .rst    (rst),
    .cfg_en (cfg_en),
    .cfg_bit(cfg_bit),
    .tbl    (tbl)
  );

  lcell_eval #(.K(K)) u_eval (
    .tbl     (tbl),
    .mode    (mode),
    .quiet   (cfg_en),
    .din     (din),
    .carry_in(carry_in),
    .lut_o   (lut_o),
    .carry_o (carry_out)
  );

  assign reg_d = chain_mode ? chain_in : lut_o;

  lcell_ff u_ff (
    .clk      (clk),
    .rst      (rst),
    .aclr     (aclr),
    .freeze   (cfg_en),
    .sclr     (sclr),
    .sload    (sload),
    .sload_val(sload_val),
    .ce       (ce),
    .d        (reg_d),
    .q        (reg_out)
  );

  assign cell_out = out_sel_reg ? reg_out : lut_o;
endmodule

// File: rtl/lcell_chk.sv
module lcell_chk #(
  parameter int K = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_en,
  input logic         arith_mode,
  input logic         out_sel_reg,
  input logic [K-1:0] din,
  input logic         ce,
  input logic         aclr,
  input logic         sclr,
  input logic         sload,
  input logic         sload_val,
  input logic         cell_out,
  input logic         reg_out,
  input logic         carry_out
);
  AST_ACLR_WINS: assert property (@(posedge clk) aclr |-> reg_out == 1'b0); // R9

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> (carry_out == 1'b0 && (out_sel_reg || cell_out == 1'b0))); // R12

  AST_CFG_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !aclr) |=> (aclr || reg_out == $past(reg_out))); // R12

  AST_SCLR_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && sclr) |=> reg_out == 1'b0); // R10

  AST_SLOAD_VAL: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !aclr && !sclr && sload) |=> (aclr || reg_out == $past(sload_val))); // R11

  AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!aclr && !sclr && !sload && !ce) |=> (aclr || $stable(reg_out))); // R7

  AST_NO_CARRY_LOGIC: assert property (@(posedge clk) disable iff (rst)
    !arith_mode |-> carry_out == 1'b0); // R5

  AST_OUT_SEL: assert property (@(posedge clk) disable iff (rst)
    out_sel_reg |-> cell_out == reg_out); // R6
endmodule

bind logic_cell lcell_chk #(.K(K)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_en     (cfg_en),
  .arith_mode (arith_mode),
  .out_sel_reg(out_sel_reg),
  .din        (din),
  .ce         (ce),
  .aclr       (aclr),
  .sclr       (sclr),
  .sload      (sload),
  .sload_val  (sload_val),
  .cell_out   (cell_out),
  .reg_out    (reg_out),
  .carry_out  (carry_out)
);

// File: tb/sim_logic_cell.sv
`timescale 1ns/1ps
module sim_logic_cell;
  localparam int K = 4;

  logic clk = 1'b0;
  logic rst, cfg_en, cfg_bit, arith_mode, out_sel_reg, chain_mode;
  logic [K-1:0] din;
  logic carry_in, chain_in, ce, aclr, sclr, sload, sload_val;
  logic cell_out, reg_out, carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] model;

  always #2.5 clk = ~clk;

  logic_cell #(.K(K)) u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .arith_mode(arith_mode), .out_sel_reg(out_sel_reg), .chain_mode(chain_mode),
    .din(din), .carry_in(carry_in), .chain_in(chain_in), .ce(ce), .aclr(aclr),
    .sclr(sclr), .sload(sload), .sload_val(sload_val),
    .cell_out(cell_out), .reg_out(reg_out), .carry_out(carry_out)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  task automatic load_table(input logic [15:0] val);
    @(negedge clk);
    cfg_en = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      cfg_bit = val[i];
      @(negedge clk);
    end
    cfg_en = 1'b0;
    model = val;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    edge_step();
    edge_step();
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(reg_out, 1'b0, "R1 reg_out");
    chk(cell_out, 1'b0, "R1 cell_out");
    chk(carry_out, 1'b0, "R1 carry_out");
  endtask

  task automatic t_order();
    load_table(16'h8000);
    din = 4'd15; #1;
    chk(cell_out, 1'b1, "R2 first bit at entry 15");
    din = 4'd0; #1;
    chk(cell_out, 1'b0, "R2 entry 0 empty");
  endtask

  task automatic t_example();
    logic [7:0] ex;
    ex = 8'b1101_1101;
    load_table({ex, ex});
    for (int c = 0; c < 8; c++) begin
      din = 4'(c); #1;
      chk(cell_out, ex[c], "R4 three-input table");
    end
  endtask

  task automatic t_normal();
    load_table(16'h6A3C);
    for (int c = 0; c < 16; c++) begin
      din = 4'(c); #1;
      chk(cell_out, model[c], "R3 general function");
      chk(carry_out, 1'b0, "R5 no carry in logic mode");
    end
  endtask

  task automatic t_arith();
    logic [15:0] t;
    for (int i = 0; i < 8; i++) begin
      t[i]     = ^i[2:0];
      t[8 + i] = (i[0] & i[1]) | (i[0] & i[2]) | (i[1] & i[2]);
    end
    load_table(t);
    arith_mode = 1'b1;
    for (int i = 0; i < 8; i++) begin
      din = {2'b11, i[1:0]};
      carry_in = i[2];
      #1;
      chk(cell_out, t[i], "R5 sum");
      chk(carry_out, t[8 + i], "R5 carry");
    end
    din = 4'b0001; carry_in = 1'b1; ce = 1'b1;
    edge_step();
    chk(reg_out, 1'b0, "R7 sum captured (1+0+1)");
    @(negedge clk);
    din = 4'b0001; carry_in = 1'b0;
    edge_step();
    chk(reg_out, 1'b1, "R7 sum captured (1+0+0)");
    @(negedge clk);
    ce = 1'b0; arith_mode = 1'b0; carry_in = 1'b0;
  endtask

  task automatic t_reg();
    load_table(16'h6A3C);
    out_sel_reg = 1'b1; ce = 1'b1;
    din = 4'd3;
    edge_step();
    chk(reg_out, model[3], "R7 capture");
    chk(cell_out, reg_out, "R6 output select");
    @(negedge clk);
    din = 4'd2;
    edge_step();
    chk(reg_out, model[2], "R7 capture second code");
    @(negedge clk);
    ce = 1'b0; din = 4'd3;
    edge_step();
    chk(reg_out, model[2], "R7 hold with ce low");
    chk(cell_out, model[2], "R6 output follows register");
    @(negedge clk);
    out_sel_reg = 1'b0;
  endtask

  task automatic t_chain();
    logic [3:0] pat;
    pat = 4'b1011;
    chain_mode = 1'b1; ce = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chain_in = pat[i];
      edge_step();
      chk(reg_out, pat[i], "R8 chain input");
    end
    @(negedge clk);
    chain_mode = 1'b0; ce = 1'b0;
  endtask

  task automatic t_ctrl();
    load_table(16'h0000);
    @(negedge clk);
    sload = 1'b1; sload_val = 1'b1; ce = 1'b1; din = 4'd0;
    edge_step();
    chk(reg_out, 1'b1, "R11 load over ce");
    @(negedge clk);
    sclr = 1'b1;
    edge_step();
    chk(reg_out, 1'b0, "R10 sclr over sload");
    @(negedge clk);
    sclr = 1'b0; ce = 1'b0;
    edge_step();
    chk(reg_out, 1'b1, "R11 load with ce low");
    @(negedge clk);
    sload = 1'b0;
  endtask

  task automatic t_aclr();
    @(negedge clk);
    aclr = 1'b1;
    #1;
    chk(reg_out, 1'b0, "R9 immediate clear");
    sload = 1'b1; sload_val = 1'b1;
    edge_step();
    chk(reg_out, 1'b0, "R9 clear overrides load");
    @(negedge clk);
    aclr = 1'b0;
    edge_step();
    chk(reg_out, 1'b1, "R11 load after clear released");
    @(negedge clk);
    sload = 1'b0;
  endtask

  task automatic t_cfg();
    load_table(16'hFFFF);
    @(negedge clk);
    cfg_en = 1'b1; cfg_bit = 1'b1; sclr = 1'b1; arith_mode = 1'b1;
    din = 4'd3; carry_in = 1'b1;
    #1;
    chk(cell_out, 1'b0, "R12 comb output quiet");
    chk(carry_out, 1'b0, "R12 carry quiet");
    edge_step();
    chk(reg_out, 1'b1, "R12 register frozen");
    @(negedge clk);
    cfg_en = 1'b0; sclr = 1'b0;
    #1;
    chk(cell_out, 1'b1, "R12 outputs return after config");
    arith_mode = 1'b0; carry_in = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cfg_en = 1'b0; cfg_bit = 1'b0; arith_mode = 1'b0;
    out_sel_reg = 1'b0; chain_mode = 1'b0; din = '0; carry_in = 1'b0;
    chain_in = 1'b0; ce = 1'b0; aclr = 1'b0; sclr = 1'b0; sload = 1'b0;
    sload_val = 1'b0; model = '0;
    t_reset();
    t_order();
    t_example();
    t_normal();
    t_arith();
    t_reg();
    t_chain();
    t_ctrl();
    t_aclr();
    t_cfg();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule